// File: doc/BRIEF.md
# Low-Power Tamper Event Detector

This block watches one phase's current while the meter sits in a low-power monitoring mode. Each strobed magnitude sample is compared with one of eight programmable levels. The block counts the rising crossings of that level, meaning a sample above the level that follows one at or below it. A window timer advances on a line-cycle tick. The window is 4 × (line-count + 1) ticks long, so it spans 12 ticks when the line-count is 2.

When the window ends, a count greater than line-count + 1 drives the active-low tamper line low. Counting carries on for as long as the block stays in monitoring mode. A tamper condition that builds up after the window has ended is therefore still reported.

By default a second active-low line reports a window that closed with no tamper. Setting a configuration bit while the block is monitoring switches it into a single-line mode, in which only a tamper event is signalled. That mode holds until the block passes through sleep. In every mode other than monitoring, all state is cleared and both lines stay high.

Top module: `lp_tamper_detect`

## Requirements
- R1: After reset, both interrupt lines are high and `win_done` is low.
- R2: The detection level for code c is (2^16 − 1) >> (c + 1). Code 0 gives 32767 and is the highest level; code 7 gives 255 and is the lowest. A sample counts as above the level only when its magnitude is strictly greater.
- R3: A crossing is counted on a valid sample that is above the level when the previous valid sample was not. A sustained high level counts once. The first sample after entering monitoring mode is compared against a "not above" history.
- R4: `win_done` rises on the clock edge that takes the tick count, counted while monitoring, to 4 × (line_cnt + 1). It stays high until the block leaves monitoring mode.
- R5: `irq_tamper_n` goes low on the same edge that `win_done` rises if the crossing count is greater than line_cnt + 1. A count equal to line_cnt + 1 does not trigger it.
- R6: Crossings are still counted after the window ends. Once `win_done` is high, `irq_tamper_n` falls on the edge where the count first exceeds line_cnt + 1. It then stays low while the block remains in monitoring mode.
- R7: In dual-line mode, `irq_aux_n` is low while `win_done` is high and no tamper is flagged. It returns high when tamper fires. The two lines are never low together.
- R8: `irq_dis_cfg` = 1 sampled while monitoring latches single-line mode. In that mode `irq_aux_n` stays high and tamper is still reported. Clearing the bit again does not leave the mode.
- R9: A cycle in `pwr_mode` = 3 (sleep) clears single-line mode, so the next monitoring session is dual-line. A visit to mode 0 or 1 leaves single-line mode unchanged.
- R10: While `pwr_mode` is not 2 (monitor), the count, history, window and tamper state are cleared. Both lines are then high and `win_done` is low.
- R11: The crossing count saturates at 63 rather than wrapping, so 70 crossings with line_cnt = 31 still flag tamper.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_mode | input | 2 | 0 full, 1 reduced, 2 monitor, 3 sleep |
| irq_dis_cfg | input | 1 | Selects single-line mode when set during monitoring |
| thr_sel | input | 3 | Detection level code |
| line_cnt | input | 5 | Line-count setting |
| line_tick | input | 1 | One pulse per line cycle |
| smp_valid | input | 1 | Sample strobe |
| smp_mag | input | 16 | Current magnitude |
| irq_tamper_n | output | 1 | Active-low tamper line |
| irq_aux_n | output | 1 | Active-low no-tamper line, used in dual-line mode |
| win_done | output | 1 | Window has elapsed |

## Verification
A stuck or stale crossing history shows up at the ports within one window. Either `irq_tamper_n` falls when a sustained level should have counted once, or it stays high when a second rise should have counted. A wrong window count moves the `win_done` edge by at least one tick. The bench compares every clock against a behavioural model, so any such error is reported on the first cycle it becomes visible. A single-line latch that leaks or never clears appears as `irq_aux_n` in the wrong state on the first window end after a mode change.

// File: rtl/lptd_pkg.sv
package lptd_pkg;
  typedef enum logic [1:0] {
    PM_FULL    = 2'd0,
    PM_REDUCED = 2'd1,
    PM_MONITOR = 2'd2,
    PM_SLEEP   = 2'd3
  } pmode_e;
endpackage

// File: rtl/lptd_edge_count.sv
module lptd_edge_count #(
  parameter int MAG_W = 16,
  parameter int SEL_W = 3,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             smp_valid,
  input  logic [MAG_W-1:0] smp_mag,
  input  logic [SEL_W-1:0] thr_sel,
  output logic [CNT_W-1:0] cnt_d,
  output logic [CNT_W-1:0] cnt_q
);
  localparam int NLVL = 2 ** SEL_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [MAG_W-1:0] lvl_tab [NLVL];
  logic             prev_q, prev_d, above;

  // level table: halves per code step, code 0 highest (R2)
  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    assign lvl_tab[g] = {MAG_W{1'b1}} >> (g + 1);
  end

  assign above = smp_mag > lvl_tab[thr_sel];

  always_comb begin
    prev_d = prev_q;
    cnt_d  = cnt_q;
    if (clr) begin
      prev_d = 1'b0;
      cnt_d  = '0;
    end else if (smp_valid) begin
      prev_d = above;
      if (above && !prev_q && (cnt_q != CNT_MAX)) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= prev_d;
      cnt_q  <= cnt_d;
    end
  end

  p_cnt_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr) |=> cnt_q == CNT_MAX);

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

  p_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0 && !prev_q);
endmodule

// File: rtl/lptd_window.sv
module lptd_window #(
  parameter int LC_W   = 5,
  parameter int UNIT   = 4,
  parameter int TICK_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            tick,
  input  logic [LC_W-1:0] line_cnt,
  output logic            done_d,
  output logic            done_q
);
  logic [TICK_W-1:0] ticks_q, ticks_d, win_len;

  assign win_len = TICK_W'((int'(line_cnt) + 1) * UNIT);

  always_comb begin
    ticks_d = ticks_q;
    done_d  = done_q;
    if (clr) begin
      ticks_d = '0;
      done_d  = 1'b0;
    end else if (tick && !done_q) begin
      ticks_d = ticks_q + 1'b1;
      done_d  = ticks_d >= win_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ticks_q <= '0;
      done_q  <= 1'b0;
    end else begin
      ticks_q <= ticks_d;
      done_q  <= done_d;
    end
  end

  p_done_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr) |=> done_q);

  p_done_needs_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_q && !tick) |=> !done_q);
endmodule

// File: rtl/lp_tamper_detect.sv
module lp_tamper_detect #(
  parameter int MAG_W = 16,
  parameter int SEL_W = 3,
  parameter int LC_W  = 5,
  parameter int UNIT  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       pwr_mode,
  input  logic             irq_dis_cfg,
  input  logic [SEL_W-1:0] thr_sel,
  input  logic [LC_W-1:0]  line_cnt,
  input  logic             line_tick,
  input  logic             smp_valid,
  input  logic [MAG_W-1:0] smp_mag,
  output logic             irq_tamper_n,
  output logic             irq_aux_n,
  output logic             win_done
);
  import lptd_pkg::*;

  localparam int CNT_W  = LC_W + 1;
  localparam int TICK_W = $clog2(UNIT * (2 ** LC_W) + 1);

  pmode_e           mode;
  logic             act, clr;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             done_d, done_q;
  logic             tamper_q, tamper_d, single_q, single_d;
  logic             over_lim;

  assign mode = pmode_e'(pwr_mode);
  assign act  = (mode == PM_MONITOR);
  assign clr  = !act;

  lptd_edge_count #(.MAG_W(MAG_W), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .smp_valid(smp_valid),
    .smp_mag(smp_mag), .thr_sel(thr_sel), .cnt_d(cnt_d), .cnt_q(cnt_q)
  );

  lptd_window #(.LC_W(LC_W), .UNIT(UNIT), .TICK_W(TICK_W)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(line_tick),
    .line_cnt(line_cnt), .done_d(done_d), .done_q(done_q)
  );

  assign over_lim = int'(cnt_d) > (int'(line_cnt) + 1);

  always_comb begin
    tamper_d = tamper_q;
    single_d = single_q;
    if (clr)                  tamper_d = 1'b0;
    else if (done_d && over_lim) tamper_d = 1'b1;
    if (mode == PM_SLEEP)     single_d = 1'b0;
    else if (act && irq_dis_cfg) single_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tamper_q <= 1'b0;
      single_q <= 1'b0;
    end else begin
      tamper_q <= tamper_d;
      single_q <= single_d;
    end
  end

  assign irq_tamper_n = ~tamper_q;
  assign irq_aux_n    = ~(done_q && !tamper_q && !single_q);
  assign win_done     = done_q;

  p_decide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act && done_d && int'(cnt_d) > int'(line_cnt) + 1) |=> !irq_tamper_n);

  p_tamper_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_tamper_n && act) |=> !irq_tamper_n);

  p_lines_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~irq_tamper_n, ~irq_aux_n}));

  p_single_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    single_q |-> irq_aux_n);

  p_sleep_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_SLEEP) |=> !single_q && irq_tamper_n);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> irq_tamper_n && irq_aux_n && !win_done);
endmodule

// File: tb/lp_tamper_detect_test.sv
module lp_tamper_detect_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  pwr_mode;
  logic        irq_dis_cfg;
  logic [2:0]  thr_sel;
  logic [4:0]  line_cnt;
  logic        line_tick;
  logic        smp_valid;
  logic [15:0] smp_mag;
  logic        irq_tamper_n, irq_aux_n, win_done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_cnt, m_ticks;
  bit m_done, m_prev, m_tamper, m_single;

  always #4 clk = ~clk;

  lp_tamper_detect uut (
    .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode), .irq_dis_cfg(irq_dis_cfg),
    .thr_sel(thr_sel), .line_cnt(line_cnt), .line_tick(line_tick),
    .smp_valid(smp_valid), .smp_mag(smp_mag), .irq_tamper_n(irq_tamper_n),
    .irq_aux_n(irq_aux_n), .win_done(win_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
    end
  endtask

  task automatic model_clear();
    m_cnt = 0; m_ticks = 0; m_done = 0; m_prev = 0; m_tamper = 0;
  endtask

  task automatic model_edge();
    bit act, above;
    int lvl;
    if (!rst_n) begin
      model_clear();
      m_single = 0;
      return;
    end
    act = (pwr_mode == 2'd2);
    if (!act) model_clear();
    else begin
      lvl = 65535 >> (int'(thr_sel) + 1);
      above = smp_mag > lvl;
      if (smp_valid) begin
        if (above && !m_prev && m_cnt < 63) m_cnt++;
        m_prev = above;
      end
      if (line_tick && !m_done) begin
        m_ticks++;
        if (m_ticks >= 4 * (int'(line_cnt) + 1)) m_done = 1;
      end
      if (m_done && m_cnt > int'(line_cnt) + 1) m_tamper = 1;
    end
    if (pwr_mode == 2'd3) m_single = 0;
    else if (act && irq_dis_cfg) m_single = 1;
  endtask

  task automatic compare();
    int exp_aux;
    exp_aux = !(m_done && !m_tamper && !m_single);
    check(irq_tamper_n == !m_tamper, cur_req, "irq_tamper_n", irq_tamper_n, !m_tamper);
    check(irq_aux_n == exp_aux, cur_req, "irq_aux_n", irq_aux_n, exp_aux);
    check(win_done == m_done, cur_req, "win_done", win_done, m_done);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cycles++;
    model_edge();
    compare();
  endtask

  task automatic drive(input bit v, input int mag, input bit tk);
    smp_valid = v; smp_mag = 16'(mag); line_tick = tk;
    step();
    smp_valid = 0; line_tick = 0;
  endtask

  task automatic rises(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      drive(1, hi, 0);
      drive(1, lo, 0);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 1);
  endtask

  task automatic set_mode(input int pm);
    pwr_mode = 2'(pm);
    step();
  endtask

  task automatic expect_out(input string req, input bit t, input bit a, input bit d);
    check(irq_tamper_n == t, req, "irq_tamper_n", irq_tamper_n, t);
    check(irq_aux_n == a, req, "irq_aux_n", irq_aux_n, a);
    check(win_done == d, req, "win_done", win_done, d);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; pwr_mode = 0; irq_dis_cfg = 0; thr_sel = 3; line_cnt = 2;
    line_tick = 0; smp_valid = 0; smp_mag = 0;
    model_clear(); m_single = 0;
    repeat (3) @(negedge clk);
    expect_out("R1", 1, 1, 0);
    rst_n = 1;
    step();
    expect_out("R1", 1, 1, 0);

    // R10: activity outside monitoring has no effect
    cur_req = "R10";
    rises(5, 5000, 100); ticks(12);
    expect_out("R10", 1, 1, 0);

    // R5: five rises, line_cnt 2, 12-tick window -> tamper at window end
    cur_req = "R5";
    set_mode(2);
    rises(5, 5000, 100);
    ticks(11);
    expect_out("R5", 1, 1, 0);
    ticks(1);
    expect_out("R5", 0, 1, 1);
    cur_req = "R10";
    set_mode(1);
    expect_out("R10", 1, 1, 0);

    // R5/R7/R6: count equal to limit, then one more after the window
    cur_req = "R7";
    set_mode(2);
    rises(3, 5000, 100);
    ticks(12);
    expect_out("R7", 1, 0, 1);
    cur_req = "R6";
    ticks(3); rises(1, 5000, 100);
    expect_out("R6", 0, 1, 1);
    ticks(2); rises(1, 5000, 100);
    expect_out("R6", 0, 1, 1);
    set_mode(0);

    // R4: exact window length, line_cnt 1 -> 8 ticks
    cur_req = "R4";
    line_cnt = 1;
    set_mode(2);
    ticks(7);
    expect_out("R4", 1, 1, 0);
    ticks(1);
    expect_out("R4", 1, 0, 1);
    set_mode(0);

    // R3: sustained high counts once; first sample compared to "not above"
    cur_req = "R3";
    line_cnt = 0;
    set_mode(2);
    for (int i = 0; i < 10; i++) drive(1, 6000, 0);
    ticks(4);
    expect_out("R3", 1, 0, 1);
    drive(1, 50, 0); drive(1, 6000, 0);
    expect_out("R3", 0, 1, 1);
    set_mode(0);

    // R2: level by code, strict compare
    cur_req = "R2";
    thr_sel = 0;
    set_mode(2);
    rises(4, 30000, 10);
    rises(3, 32767, 10);
    ticks(4);
    expect_out("R2", 1, 0, 1);
    thr_sel = 7;
    rises(3, 255, 10);
    expect_out("R2", 1, 0, 1);
    rises(2, 256, 10);
    expect_out("R2", 0, 1, 1);
    set_mode(0);
    thr_sel = 3;

    // R8: single-line mode
    cur_req = "R8";
    irq_dis_cfg = 1;
    set_mode(2);
    irq_dis_cfg = 0;
    ticks(4);
    expect_out("R8", 1, 1, 1);
    rises(2, 5000, 100);
    expect_out("R8", 0, 1, 1);

    // R9: full mode keeps single-line mode, sleep clears it
    cur_req = "R9";
    set_mode(0);
    set_mode(2);
    ticks(4);
    expect_out("R9", 1, 1, 1);
    set_mode(3);
    set_mode(2);
    ticks(4);
    expect_out("R9", 1, 0, 1);
    set_mode(0);

    // R11: saturation, line_cnt 31, 70 rises
    cur_req = "R11";
    line_cnt = 31;
    set_mode(2);
    rises(70, 5000, 100);
    ticks(127);
    expect_out("R11", 1, 1, 0);
    ticks(1);
    expect_out("R11", 0, 1, 1);
    set_mode(0);

    // R1: reset mid-activity returns to idle
    cur_req = "R1";
    line_cnt = 0;
    set_mode(2);
    rises(2, 5000, 100); ticks(4);
    expect_out("R1", 0, 1, 1);
    rst_n = 0;
    @(negedge clk);
    model_edge();
    expect_out("R1", 1, 1, 0);
    rst_n = 1;
    step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule